// File: doc/BRIEF.md
# Quad-SPI Single-Byte Read Engine

This block fetches one byte at a random 24-bit address from a serial memory that uses four data lines. A one-cycle trigger with an address starts a frame. Chip select goes low and, after a programmable lead-in, the block sends the read command and the address four bits per serial clock. It then releases the data lines for the turnaround clocks and samples the returned byte in two nibbles. The byte is presented with a single-cycle valid pulse.

The serial clock is the system clock divided by a fixed parameter. Three chip-select timings are counted in serial clocks: the lead-in before the first clock edge, the lag after the last edge, and the minimum deselect gap between two accesses. The gap has a scale selector. The valid pulse is raised as soon as the second nibble is in, so the lag never adds latency.

A trigger that arrives while a frame or gap is running is stored in a single slot and launched when the block returns to idle. A trigger that arrives while the slot is full is dropped and flagged.

Top module: `qspi_byte_reader`

## Requirements
- R1: After reset, `cs_n` is high and `sclk`, `dq_oe`, `rd_valid` and `overrun` are low.
- R2: A frame has exactly 14 rising edges of `sclk`. The 8-bit command (default 8'hEB) goes out as two nibbles, followed by the 24 address bits as six nibbles, most significant nibble first. Each nibble is placed on `dq_out` while `sclk` is low and held through the next rising edge.
- R3: `dq_oe` is high for rising edges 1 to 8 and low from edge 9 until `cs_n` rises. The byte is sampled on rising edges 13 (bits 7:4) and 14 (bits 3:0).
- R4: With setup count S and divider D, `rd_valid` is first high (S+13)*D + (D - floor(D/2)) system cycles after the clock edge that samples the trigger. The `sclk` high half is floor(D/2) cycles long and the low half takes the rest.
- R5: `cs_n` stays low for (S+14+H)*D system cycles, where H is the hold count. `rd_valid` is raised while `cs_n` is still low, and its timing does not depend on H.
- R6: `rd_valid` is high for exactly one system cycle. `rd_data` holds its value until the next pulse.
- R7: When a queued request follows an access, `cs_n` is high between the two for I*M*D + 1 system cycles. Here I is the interval count and M is 1 when `cfg_ivl_unit` is 0, or 256 when it is 1.
- R8: The interval count does not delay an access that starts after the gap has expired. Such an access still meets the latency of R4.
- R9: A trigger that arrives while the block is not idle and the slot is empty is queued and later executed. A trigger that arrives while the slot is full is dropped, and `overrun` pulses in the next cycle.
- R10: A trigger in the same cycle that the queued request launches is itself queued. It is not dropped, and all three reads complete in order.
- R11: `sclk` is low whenever `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle read trigger |
| req_addr | input | 24 | Byte address of the read |
| cfg_setup | input | 5 | CS-low to first edge, in serial clocks |
| cfg_hold | input | 5 | Last edge to CS-high, in serial clocks |
| cfg_ivl | input | 8 | Minimum CS-high gap count |
| cfg_ivl_unit | input | 1 | Gap scale: 0 = x1, 1 = x256 serial clocks |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles low |
| dq_out | output | 4 | Data lines driven toward memory |
| dq_oe | output | 1 | Output enable for `dq_out` |
| dq_in | input | 4 | Data lines sampled from memory |
| rd_valid | output | 1 | One-cycle result strobe |
| rd_data | output | 8 | Captured byte |
| overrun | output | 1 | Pulse when a trigger is dropped |

## Verification
Two functions can fall in the same cycle: launching the stored request and accepting a fresh trigger into the slot that launch frees. The bench provokes this by counting gap cycles after `cs_n` rises and asserting a trigger on exactly the launch edge. It then requires no `overrun` pulse and all three results in order. The completion strobe and the chip-select lag also overlap: the bench runs hold counts of 0 and 31 and requires the same latency, with `cs_n` still low when `rd_valid` is seen.

// File: rtl/qbr_pkg.sv
package qbr_pkg;

  typedef enum logic [2:0] {
    QS_IDLE,
    QS_SETUP,
    QS_FRAME,
    QS_HOLD,
    QS_GAP
  } qbr_state_e;

  // serial clocks spent on the command byte and on the returned byte
  localparam int CMD_CLKS  = 2;
  localparam int DATA_CLKS = 2;

  // total serial clocks of one frame
  function automatic int qbr_frame_clks(input int addr_w, input int dummy);
    return CMD_CLKS + addr_w / 4 + dummy + DATA_CLKS;
  endfunction

  // system cycles covered by n serial clocks
  function automatic int qbr_span(input int n, input int div);
    return n * div;
  endfunction

  // system cycles of the deselect gap, with optional x256 scale
  function automatic int qbr_gap(input int n, input logic wide, input int div);
    return n * (wide ? 256 : 1) * div;
  endfunction

  // system cycles of the low half of one serial clock
  function automatic int qbr_low_half(input int div);
    return div - div / 2;
  endfunction

endpackage

// File: rtl/qbr_intake.sv
module qbr_intake
  import qbr_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              idle,
  output logic              start,
  output logic [ADDR_W-1:0] start_addr,
  output logic              overrun
);

  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q;

  assign start      = idle && (pend_q || req_valid);
  assign start_addr = pend_q ? pend_addr_q : req_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      overrun     <= 1'b0;
    end else begin
      overrun <= 1'b0;
      if (idle) begin
        if (pend_q) begin
          // stored request launches now; a fresh trigger takes its slot
          pend_q <= req_valid;
          if (req_valid) pend_addr_q <= req_addr;
        end
      end else if (req_valid) begin
        if (!pend_q) begin
          pend_q      <= 1'b1;
          pend_addr_q <= req_addr;
        end else begin
          overrun <= 1'b1;
        end
      end
    end
  end

  assert_overrun_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(pend_q) && $past(req_valid));

endmodule

// File: rtl/qbr_sequencer.sv
module qbr_sequencer
  import qbr_pkg::*;
#(
  parameter int          CLK_DIV    = 2,
  parameter int          ADDR_W     = 24,
  parameter int          CS_W       = 5,
  parameter int          IVL_W      = 8,
  parameter int          DUMMY_CLKS = 4,
  parameter logic [7:0]  READ_CMD   = 8'hEB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CS_W-1:0]   cfg_setup,
  input  logic [CS_W-1:0]   cfg_hold,
  input  logic [IVL_W-1:0]  cfg_ivl,
  input  logic              cfg_ivl_unit,
  output logic              idle,
  output logic              cs_n,
  output logic              sclk,
  output logic [3:0]        dq_out,
  output logic              dq_oe,
  output logic              cap_strobe,
  output logic              cap_last
);

  localparam int FRAME_CLKS = qbr_frame_clks(ADDR_W, DUMMY_CLKS);
  localparam int DRIVE_CLKS = CMD_CLKS + ADDR_W / 4;
  localparam int DATA_FIRST = FRAME_CLKS - DATA_CLKS;
  localparam int LAST_BIT   = FRAME_CLKS - 1;
  localparam int BIT_W      = $clog2(FRAME_CLKS);
  localparam int PH_W       = $clog2(CLK_DIV);
  localparam int LO         = qbr_low_half(CLK_DIV);
  localparam int WIDE_W     = ((IVL_W + 8) > CS_W) ? (IVL_W + 8) : CS_W;
  localparam int SPAN_W     = WIDE_W + PH_W + 1;
  localparam int WORD_W     = 8 + ADDR_W;

  qbr_state_e        st_q;
  logic [SPAN_W-1:0] cnt_q;
  logic [PH_W-1:0]   ph_q;
  logic [BIT_W-1:0]  bit_q;
  logic [WORD_W-1:0] word_q;

  logic [SPAN_W-1:0] setup_cyc, hold_cyc, gap_cyc;
  logic              ph_wrap, frame_done;
  logic [WORD_W-1:0] word_sh;

  assign setup_cyc = SPAN_W'(qbr_span(int'(cfg_setup), CLK_DIV));
  assign hold_cyc  = SPAN_W'(qbr_span(int'(cfg_hold), CLK_DIV));
  assign gap_cyc   = SPAN_W'(qbr_gap(int'(cfg_ivl), cfg_ivl_unit, CLK_DIV));

  assign ph_wrap    = (ph_q == PH_W'(CLK_DIV - 1));
  assign frame_done = (st_q == QS_FRAME) && ph_wrap && (bit_q == BIT_W'(LAST_BIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= QS_IDLE;
      cnt_q  <= '0;
      ph_q   <= '0;
      bit_q  <= '0;
      word_q <= '0;
    end else begin
      case (st_q)
        QS_IDLE: begin
          if (start) begin
            word_q <= {READ_CMD, start_addr};
            ph_q   <= '0;
            bit_q  <= '0;
            if (setup_cyc == '0) begin
              st_q <= QS_FRAME;
            end else begin
              st_q  <= QS_SETUP;
              cnt_q <= setup_cyc - 1'b1;
            end
          end
        end
        QS_SETUP: begin
          if (cnt_q == '0) st_q <= QS_FRAME;
          else             cnt_q <= cnt_q - 1'b1;
        end
        QS_FRAME: begin
          if (!ph_wrap) begin
            ph_q <= ph_q + 1'b1;
          end else begin
            ph_q <= '0;
            if (!frame_done) begin
              bit_q <= bit_q + 1'b1;
            end else if (hold_cyc != '0) begin
              st_q  <= QS_HOLD;
              cnt_q <= hold_cyc - 1'b1;
            end else if (gap_cyc != '0) begin
              st_q  <= QS_GAP;
              cnt_q <= gap_cyc - 1'b1;
            end else begin
              st_q <= QS_IDLE;
            end
          end
        end
        QS_HOLD: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (gap_cyc != '0) begin
            st_q  <= QS_GAP;
            cnt_q <= gap_cyc - 1'b1;
          end else begin
            st_q <= QS_IDLE;
          end
        end
        QS_GAP: begin
          if (cnt_q == '0) st_q <= QS_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= QS_IDLE;
      endcase
    end
  end

  // pin decode
  assign idle    = (st_q == QS_IDLE);
  assign cs_n    = !((st_q == QS_SETUP) || (st_q == QS_FRAME) || (st_q == QS_HOLD));
  assign sclk    = (st_q == QS_FRAME) && (ph_q >= PH_W'(LO));
  assign dq_oe   = (st_q == QS_SETUP) ||
                   ((st_q == QS_FRAME) && (bit_q < BIT_W'(DRIVE_CLKS)));
  assign word_sh = word_q << {bit_q, 2'b00};
  assign dq_out  = word_sh[WORD_W-1 -: 4];

  // sample point: the system edge on which sclk rises in a data clock
  assign cap_strobe = (st_q == QS_FRAME) && (ph_q == PH_W'(LO - 1)) &&
                      (bit_q >= BIT_W'(DATA_FIRST));
  assign cap_last   = cap_strobe && (bit_q == BIT_W'(LAST_BIT));

  assert_nibble_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk) && dq_oe) |-> $stable(dq_out));

  assert_clock_stops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !sclk);

endmodule

// File: rtl/qbr_result.sv
module qbr_result (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_strobe,
  input  logic       cap_last,
  input  logic [3:0] dq_in,
  output logic       rd_valid,
  output logic [7:0] rd_data
);

  logic [3:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q     <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (cap_strobe) begin
        if (cap_last) begin
          rd_data  <= {hi_q, dq_in};
          rd_valid <= 1'b1;
        end else begin
          hi_q <= dq_in;
        end
      end
    end
  end

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_data_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data));

endmodule

// File: rtl/qspi_byte_reader.sv
module qspi_byte_reader
  import qbr_pkg::*;
#(
  parameter int         CLK_DIV    = 2,
  parameter int         ADDR_W     = 24,
  parameter int         CS_W       = 5,
  parameter int         IVL_W      = 8,
  parameter int         DUMMY_CLKS = 4,
  parameter logic [7:0] READ_CMD   = 8'hEB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CS_W-1:0]   cfg_setup,
  input  logic [CS_W-1:0]   cfg_hold,
  input  logic [IVL_W-1:0]  cfg_ivl,
  input  logic              cfg_ivl_unit,
  output logic              cs_n,
  output logic              sclk,
  output logic [3:0]        dq_out,
  output logic              dq_oe,
  input  logic [3:0]        dq_in,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              overrun
);

  logic              idle, start, cap_strobe, cap_last;
  logic [ADDR_W-1:0] start_addr;

  qbr_intake #(.ADDR_W(ADDR_W)) u_intake (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .idle       (idle),
    .start      (start),
    .start_addr (start_addr),
    .overrun    (overrun)
  );

  qbr_sequencer #(
    .CLK_DIV    (CLK_DIV),
    .ADDR_W     (ADDR_W),
    .CS_W       (CS_W),
    .IVL_W      (IVL_W),
    .DUMMY_CLKS (DUMMY_CLKS),
    .READ_CMD   (READ_CMD)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .start_addr   (start_addr),
    .cfg_setup    (cfg_setup),
    .cfg_hold     (cfg_hold),
    .cfg_ivl      (cfg_ivl),
    .cfg_ivl_unit (cfg_ivl_unit),
    .idle         (idle),
    .cs_n         (cs_n),
    .sclk         (sclk),
    .dq_out       (dq_out),
    .dq_oe        (dq_oe),
    .cap_strobe   (cap_strobe),
    .cap_last     (cap_last)
  );

  qbr_result u_result (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_strobe (cap_strobe),
    .cap_last   (cap_last),
    .dq_in      (dq_in),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

  assert_sclk_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  assert_valid_in_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !cs_n);

  assert_bus_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |-> !dq_oe);

endmodule

// File: tb/tb_qspi_byte_reader.sv
`timescale 1ns/1ps
module tb_qspi_byte_reader;

  localparam int DIV = 2;
  localparam int LO  = DIV - DIV / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic [4:0]  cfg_setup = 5'd3;
  logic [4:0]  cfg_hold = 5'd3;
  logic [7:0]  cfg_ivl = 8'd2;
  logic        cfg_ivl_unit = 1'b0;
  logic        cs_n, sclk, dq_oe, rd_valid, overrun;
  logic [3:0]  dq_out;
  logic [3:0]  dq_in = '0;
  logic [7:0]  rd_data;

  always #2 clk = ~clk;

  qspi_byte_reader #(.CLK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .cfg_setup(cfg_setup), .cfg_hold(cfg_hold), .cfg_ivl(cfg_ivl),
    .cfg_ivl_unit(cfg_ivl_unit), .cs_n(cs_n), .sclk(sclk), .dq_out(dq_out),
    .dq_oe(dq_oe), .dq_in(dq_in), .rd_valid(rd_valid), .rd_data(rd_data),
    .overrun(overrun)
  );

  int checks = 0, fails = 0, nres = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'hA5;
  endfunction

  function automatic int lat_cycles(input int s);
    return (s + 13) * DIV + LO + 1;
  endfunction

  function automatic int cs_low_cycles(input int s, input int h);
    return (s + 14 + h) * DIV;
  endfunction

  function automatic int cs_gap_cycles(input int i, input bit wide);
    return i * (wide ? 256 : 1) * DIV + 1;
  endfunction

  // memory model: collects command/address, returns data nibbles
  logic        prev_sclk = 1'b0, prev_cs = 1'b1;
  int          ec = 0;
  logic [31:0] sr = '0;
  logic [7:0]  mdat = '0;
  bit          oe_bad = 1'b0, idle_ok = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_n) begin
        if (sclk) idle_ok = 1'b0;
        if (!prev_cs) begin
          check(ec == 14, "R2 rising edges per frame", ec, 14);
          check(!oe_bad, "R3 drive window", int'(oe_bad), 0);
        end
        ec = 0;
        dq_in = '0;
      end else begin
        if (prev_cs) begin
          check(idle_ok, "R11 sclk low while deselected", int'(!idle_ok), 0);
          idle_ok = 1'b1;
          oe_bad  = 1'b0;
        end
        if (sclk && !prev_sclk) begin
          ec++;
          if (ec <= 8) begin
            sr = {sr[27:0], dq_out};
            if (!dq_oe) oe_bad = 1'b1;
          end else if (dq_oe) begin
            oe_bad = 1'b1;
          end
          if (ec == 8) begin
            check(sr[31:24] == 8'hEB, "R2 command byte", int'(sr[31:24]), 'hEB);
            mdat = mem_byte(sr[23:0]);
          end
          if (ec == 12) dq_in = mdat[7:4];
          if (ec == 13) dq_in = mdat[3:0];
        end
      end
    end
    prev_sclk = sclk;
    prev_cs   = cs_n;
  end

  // scoreboard monitor and chip-select run lengths
  bit         prev_valid = 1'b0, data_steady = 1'b1, prev_cs2 = 1'b1;
  logic [7:0] last_data = '0;
  int         low_run = 0, high_run = 0, last_low = 0, last_high = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid) begin
        check(!cs_n, "R5 result before deselect", int'(cs_n), 0);
        check(!prev_valid, "R6 one-cycle strobe", int'(prev_valid), 0);
        check(data_steady, "R6 byte held between strobes", int'(!data_steady), 0);
        data_steady = 1'b1;
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected result", int'(rd_data), -1);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(rd_data == e, "R2 returned byte", int'(rd_data), int'(e));
          nres++;
        end
        last_data = rd_data;
      end else if (rd_data != last_data) begin
        data_steady = 1'b0;
      end
      prev_valid = rd_valid;
      if (cs_n) begin
        if (!prev_cs2) last_low = low_run;
        high_run++;
        low_run = 0;
      end else begin
        if (prev_cs2) last_high = high_run;
        low_run++;
        high_run = 0;
      end
      prev_cs2 = cs_n;
    end
  end

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input int s, input int h, input int i, input bit u);
    @(negedge clk);
    cfg_setup = 5'(s); cfg_hold = 5'(h); cfg_ivl = 8'(i); cfg_ivl_unit = u;
  endtask

  // driver: one trigger, expected byte pushed unless it is to be dropped
  task automatic issue(input logic [23:0] a, input bit drop, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    if (!drop) exp_q.push_back(mem_byte(a));
    @(negedge clk);
    req_valid = 1'b0;
    check(overrun == drop, req, int'(overrun), int'(drop));
  endtask

  task automatic timed_read(input logic [23:0] a, input int s, input string req);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    exp_q.push_back(mem_byte(a));
    n = 0;
    forever begin
      @(negedge clk);
      req_valid = 1'b0;
      n++;
      if (rd_valid || n > 3000) break;
    end
    check(n == lat_cycles(s), req, n, lat_cycles(s));
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    settle(5);
    check(cs_n == 1'b1, "R1 cs_n after reset", int'(cs_n), 1);
    check(sclk == 1'b0, "R1 sclk after reset", int'(sclk), 0);
    check(dq_oe == 1'b0, "R1 dq_oe after reset", int'(dq_oe), 0);
    check(rd_valid == 1'b0, "R1 rd_valid after reset", int'(rd_valid), 0);
    check(overrun == 1'b0, "R1 overrun after reset", int'(overrun), 0);
    rst_n = 1'b1;
    settle(3);

    // R4 / R5: default timing
    timed_read(24'h123456, 3, "R4 latency setup=3");
    settle(40);
    check(last_low == cs_low_cycles(3, 3), "R5 CS low s3 h3", last_low, cs_low_cycles(3, 3));

    set_cfg(0, 0, 2, 1'b0);
    settle(10);
    timed_read(24'hABCDEF, 0, "R4 latency setup=0");
    settle(40);
    check(last_low == cs_low_cycles(0, 0), "R5 CS low s0 h0", last_low, cs_low_cycles(0, 0));

    set_cfg(10, 3, 2, 1'b0);
    settle(10);
    timed_read(24'h00F00F, 10, "R4 latency setup=10");
    settle(60);
    check(last_low == cs_low_cycles(10, 3), "R5 CS low s10 h3", last_low, cs_low_cycles(10, 3));

    set_cfg(3, 31, 2, 1'b0);
    settle(10);
    timed_read(24'hFFFFFF, 3, "R5 hold does not delay result");
    settle(120);
    check(last_low == cs_low_cycles(3, 31), "R5 CS low s3 h31", last_low, cs_low_cycles(3, 31));

    // R9 / R7: queue one, drop one
    set_cfg(3, 3, 2, 1'b0);
    settle(10);
    base = nres;
    issue(24'h010203, 1'b0, "R9 idle trigger accepted");
    settle(3);
    issue(24'h040506, 1'b0, "R9 busy trigger queued");
    issue(24'h070809, 1'b1, "R9 overrun on full slot");
    settle(200);
    check(nres - base == 2, "R9 results for queued reads", nres - base, 2);
    check(last_high == cs_gap_cycles(2, 1'b0), "R7 gap unit x1", last_high, cs_gap_cycles(2, 1'b0));

    set_cfg(3, 3, 1, 1'b1);
    settle(10);
    issue(24'h5A5A5A, 1'b0, "R9 idle trigger accepted");
    settle(3);
    issue(24'hA5A5A5, 1'b0, "R9 busy trigger queued");
    settle(700);
    check(last_high == cs_gap_cycles(1, 1'b1), "R7 gap unit x256", last_high, cs_gap_cycles(1, 1'b1));

    // R8: long interval, isolated reads
    set_cfg(3, 3, 3, 1'b1);
    settle(2000);
    timed_read(24'h13579B, 3, "R8 isolated read, long interval");
    settle(2000);
    timed_read(24'h2468AC, 3, "R8 second isolated read");

    // R10: trigger on the launch cycle of the stored request
    set_cfg(3, 3, 2, 1'b0);
    settle(2000);
    base = nres;
    issue(24'h111111, 1'b0, "R10 first read accepted");
    settle(2);
    issue(24'h222222, 1'b0, "R10 second read queued");
    do @(negedge clk); while (!cs_n);
    repeat (2 * DIV - 1) @(negedge clk);
    issue(24'h333333, 1'b0, "R10 trigger on launch cycle kept");
    settle(200);
    check(nres - base == 3, "R10 three results", nres - base, 3);
    check(last_high == cs_gap_cycles(2, 1'b0), "R10 queued launch gap", last_high, cs_gap_cycles(2, 1'b0));

    check(exp_q.size() == 0, "R9 every expected result returned", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule